// File: doc/BRIEF.md
# Dual-Port Processor and DMA Bus Interface

This block connects an 8-bit processor bus and an 8-bit DMA data bus to a small internal register file and a byte FIFO. The processor reaches every register, the FIFO slot included, through an active-low chip select, a register address and separate active-low read and write strobes. A strap input picks how the processor bus is used. With the strap low, the bus carries data only and four dedicated pins hold the register address. With the strap high, the bus carries both address and data, and two of the address pins change role: one becomes the address latch enable and the other the DMA read strobe.

The DMA port reaches only the FIFO. It uses an active-low acknowledge, a write strobe that pushes a byte and a read strobe that pops one, and it carries an odd parity bit next to the data. Both ports may be active at once, as long as the processor is not also aimed at the FIFO. All pins are asynchronous to the block clock. Every strobe and qualifier passes through a synchroniser, and each transfer is committed once, on the synchronised rising edge of its strobe. The output enables for the two buses follow the raw pins directly.

Top module: `hostdma_if`

## Requirements
- R1: After reset the FIFO is empty, the four sticky flags (parity_err, clash_err, overflow, underflow) are 0, and with all strobes high both pad_oe and db_oe are 0.
- R2: With mux_mode low, adr_i[3:0] selects one of 16 registers. A processor write (cs_n low, wr_n pulsed low then high) stores pad_i in that register. A read (cs_n and rd_n low) returns the stored byte on pad_o.
- R3: With mux_mode high, the register address is taken from pad_i[3:0] when adr_i[3] (latch enable) falls, adr_i[2] is the DMA read strobe, adr_i[1:0] and dma_rd_n are ignored, and registers and FIFO otherwise behave as in R2, R5 and R6.
- R4: pad_oe is 1 exactly while cs_n and rd_n are both low. db_oe is 1 exactly while dack_n and the active DMA read strobe are both low.
- R5: A DMA write (dack_n low, dwr_n pulsed) pushes db_i into the FIFO, and bytes leave in the order they entered.
- R6: While db_oe is 1, db_o shows the FIFO head and dbp_o is set so that the nine bits hold an odd number of ones. A DMA read pops that byte.
- R7: Register address 15 is the FIFO. A processor write there pushes pad_i, and a processor read there shows and pops the head, while dack_n is high.
- R8: A processor access to address 15 while dack_n is low neither pushes nor pops, and it sets clash_err. Processor accesses to other addresses work normally while dack_n is low.
- R9: A DMA write whose nine bits hold an even number of ones sets parity_err. The byte is still stored.
- R10: A push into a full FIFO (depth 8) is dropped and sets overflow. The stored bytes are unchanged.
- R11: A pop from an empty FIFO is dropped, sets underflow and leaves the FIFO empty.
- R12: A strobe moves exactly one byte however long it is held low. The move takes effect after the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_mode | input | 1 | Strap: 1 = shared address/data bus |
| pad_i | input | 8 | Processor bus, incoming |
| pad_o | output | 8 | Processor bus, outgoing |
| pad_oe | output | 1 | Processor bus drive enable |
| adr_i | input | 4 | Register address; in shared mode [3] is latch enable and [2] is DMA read strobe |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| dack_n | input | 1 | DMA acknowledge, active low |
| dwr_n | input | 1 | DMA write strobe, active low |
| dma_rd_n | input | 1 | DMA read strobe in data-only mode, active low |
| db_i | input | 8 | DMA data, incoming |
| dbp_i | input | 1 | DMA parity, incoming |
| db_o | output | 8 | DMA data, outgoing |
| dbp_o | output | 1 | DMA parity, outgoing |
| db_oe | output | 1 | DMA bus drive enable |
| parity_err | output | 1 | Sticky: even parity seen on a DMA write |
| clash_err | output | 1 | Sticky: processor FIFO access rejected |
| overflow | output | 1 | Sticky: push into full FIFO |
| underflow | output | 1 | Sticky: pop from empty FIFO |

## Verification
The assertions assume that the strap changes only under reset and that a strobe never rises while its own qualifier is also changing. The stimulus keeps each address, data byte and qualifier steady for several cycles on either side of every strobe edge. The assertions also assume that a DMA write and a processor FIFO write never commit in the same cycle, and the stimulus never overlaps them. All pin changes are made on the falling clock edge, well clear of the synchronisers' sampling edge.

// File: rtl/hdi_pkg.sv
package hdi_pkg;
    localparam int BW = 8;
    localparam int AW = 4;

    typedef logic [BW-1:0] byte_t;
    typedef logic [AW-1:0] radr_t;

    typedef struct packed {
        radr_t adr;
        byte_t dat;
    } cpu_xfer_t;

    typedef struct packed {
        logic par;
        logic clash;
        logic ovf;
        logic unf;
    } sticky_t;

    // parity bit that makes the nine bits odd
    function automatic logic odd_bit(byte_t d);
        return ~^d;
    endfunction

    // true when the nine bits hold an even number of ones
    function automatic logic nine_even(byte_t d, logic p);
        return ~^{p, d};
    endfunction
endpackage

// File: rtl/hdi_sync.sv
module hdi_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RSTV   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RSTV;
                else     chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RSTV;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hdi_strobe.sv
// Arms while strobe and qualifier are low, records the payload and
// an OR of the flag over the window, fires once on the strobe's rise.
module hdi_strobe #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strb_n,
    input  logic          qual_n,
    input  logic [PW-1:0] pay_i,
    input  logic          flag_i,
    output logic          fire,
    output logic [PW-1:0] pay_o,
    output logic          flag_o
);
    logic prev_n;
    logic armed;

    assign fire = armed & strb_n & ~prev_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n <= 1'b1;
            armed  <= 1'b0;
            pay_o  <= '0;
            flag_o <= 1'b0;
        end else begin
            prev_n <= strb_n;
            if (!strb_n && !qual_n) begin
                armed  <= 1'b1;
                pay_o  <= pay_i;
                flag_o <= armed ? (flag_o | flag_i) : flag_i;
            end else if (fire) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hdi_fifo.sv
module hdi_fifo #(
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  hdi_pkg::byte_t din,
    output hdi_pkg::byte_t dout,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    hdi_pkg::byte_t mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [CW-1:0]  level;
    logic           do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= bump(wp);
            end
            if (do_pop) rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/hdi_addr.sv
module hdi_addr (
    input  logic          clk,
    input  logic          rst,
    input  logic          mux_mode,
    input  logic          ale_s,
    input  hdi_pkg::radr_t pad_lo_s,
    input  hdi_pkg::radr_t adr_s,
    output hdi_pkg::radr_t cur_adr
);
    logic           ale_prev;
    hdi_pkg::radr_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_prev <= 1'b0;
            held     <= '0;
        end else begin
            ale_prev <= ale_s;
            if (ale_prev && !ale_s) held <= pad_lo_s;
        end
    end

    assign cur_adr = mux_mode ? held : adr_s;
endmodule

// File: rtl/hostdma_if.sv
module hostdma_if #(
    parameter int          FIFO_DEPTH  = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  FIFO_ADDR   = 4'hF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mux_mode,
    input  logic [7:0] pad_i,
    output logic [7:0] pad_o,
    output logic       pad_oe,
    input  logic [3:0] adr_i,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       dack_n,
    input  logic       dwr_n,
    input  logic       dma_rd_n,
    input  logic [7:0] db_i,
    input  logic       dbp_i,
    output logic [7:0] db_o,
    output logic       dbp_o,
    output logic       db_oe,
    output logic       parity_err,
    output logic       clash_err,
    output logic       overflow,
    output logic       underflow
);
    import hdi_pkg::*;

    localparam int NREG = 2 ** AW;
    localparam int CTLW = 7;
    localparam int DATW = BW + AW + BW + 1;

    // pin roles chosen by the strap
    logic drd_raw, ale_raw;
    assign drd_raw = mux_mode ? adr_i[2] : dma_rd_n;
    assign ale_raw = mux_mode & adr_i[3];

    // bus drive follows the raw pins
    assign pad_oe = ~cs_n & ~rd_n;
    assign db_oe  = ~dack_n & ~drd_raw;

    // synchronisers
    logic cs_s, rd_s, wr_s, dack_s, dwr_s, drd_s, ale_s;
    byte_t pad_s, db_s;
    radr_t adr_s;
    logic  dbp_s;

    hdi_sync #(.W(CTLW), .STAGES(SYNC_STAGES), .RSTV(7'b1111110)) u_sync_ctl (
        .clk(clk), .rst(rst),
        .d({cs_n, rd_n, wr_n, dack_n, dwr_n, drd_raw, ale_raw}),
        .q({cs_s, rd_s, wr_s, dack_s, dwr_s, drd_s, ale_s})
    );

    hdi_sync #(.W(DATW), .STAGES(SYNC_STAGES), .RSTV('0)) u_sync_dat (
        .clk(clk), .rst(rst),
        .d({pad_i, adr_i, db_i, dbp_i}),
        .q({pad_s, adr_s, db_s, dbp_s})
    );

    // address source
    radr_t cur_adr;
    logic  fifo_hit;

    hdi_addr u_addr (
        .clk(clk), .rst(rst), .mux_mode(mux_mode), .ale_s(ale_s),
        .pad_lo_s(pad_s[AW-1:0]), .adr_s(adr_s), .cur_adr(cur_adr)
    );

    assign fifo_hit = (cur_adr == FIFO_ADDR);

    // processor write
    logic      cwr_fire, cwr_flag;
    cpu_xfer_t cwr_x;
    hdi_strobe #(.PW($bits(cpu_xfer_t))) u_cwr (
        .clk(clk), .rst(rst), .strb_n(wr_s), .qual_n(cs_s),
        .pay_i({cur_adr, pad_s}), .flag_i(fifo_hit & ~dack_s),
        .fire(cwr_fire), .pay_o(cwr_x), .flag_o(cwr_flag)
    );

    // processor read
    logic  crd_fire, crd_flag;
    radr_t crd_adr;
    hdi_strobe #(.PW(AW)) u_crd (
        .clk(clk), .rst(rst), .strb_n(rd_s), .qual_n(cs_s),
        .pay_i(cur_adr), .flag_i(fifo_hit & ~dack_s),
        .fire(crd_fire), .pay_o(crd_adr), .flag_o(crd_flag)
    );

    // DMA write, flag tracks even parity in the window
    logic  dwr_fire, dwr_flag;
    byte_t dwr_dat;
    hdi_strobe #(.PW(BW)) u_dwr (
        .clk(clk), .rst(rst), .strb_n(dwr_s), .qual_n(dack_s),
        .pay_i(db_s), .flag_i(nine_even(db_s, dbp_s)),
        .fire(dwr_fire), .pay_o(dwr_dat), .flag_o(dwr_flag)
    );

    // DMA read needs no payload
    logic drd_prev, drd_armed, drd_fire;
    assign drd_fire = drd_armed & drd_s & ~drd_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            drd_prev  <= 1'b1;
            drd_armed <= 1'b0;
        end else begin
            drd_prev <= drd_s;
            if (!drd_s && !dack_s) drd_armed <= 1'b1;
            else if (drd_fire)     drd_armed <= 1'b0;
        end
    end

    // steering
    logic  cwr_hit, crd_hit;
    logic  push_req, pop_req, clash_evt;
    byte_t push_dat, head;
    logic  fifo_full, fifo_empty;

    assign cwr_hit   = (cwr_x.adr == FIFO_ADDR);
    assign crd_hit   = (crd_adr == FIFO_ADDR);
    assign push_req  = dwr_fire | (cwr_fire & cwr_hit & ~cwr_flag);
    assign push_dat  = dwr_fire ? dwr_dat : cwr_x.dat;
    assign pop_req   = drd_fire | (crd_fire & crd_hit & ~crd_flag);
    assign clash_evt = (cwr_fire & cwr_hit & cwr_flag) |
                       (crd_fire & crd_hit & crd_flag);

    hdi_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push_req), .pop(pop_req),
        .din(push_dat), .dout(head), .full(fifo_full), .empty(fifo_empty)
    );

    // register file
    byte_t regs [NREG];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (cwr_fire && !cwr_hit) begin
            regs[cwr_x.adr] <= cwr_x.dat;
        end
    end

    // sticky status
    sticky_t st;
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.par   <= st.par   | (dwr_fire & dwr_flag);
            st.clash <= st.clash | clash_evt;
            st.ovf   <= st.ovf   | (push_req & fifo_full);
            st.unf   <= st.unf   | (pop_req & fifo_empty);
        end
    end

    assign parity_err = st.par;
    assign clash_err  = st.clash;
    assign overflow   = st.ovf;
    assign underflow  = st.unf;

    assign pad_o = fifo_hit ? head : regs[cur_adr];
    assign db_o  = head;
    assign dbp_o = odd_bit(head);
endmodule

// File: rtl/hdi_chk.sv
module hdi_chk #(
    parameter int DEPTH = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         push_req,
    input logic                         pop_req,
    input logic                         full,
    input logic                         empty,
    input logic [$clog2(DEPTH+1)-1:0]   level,
    input logic                         parity_err,
    input logic                         clash_err,
    input logic                         overflow,
    input logic                         underflow,
    input logic                         db_oe,
    input logic [7:0]                   db_o,
    input logic                         dbp_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: state is clear in the first cycle after reset
    always @(posedge clk) begin
        if (!rst && rst_q) begin
            a_r1_reset_clear: assert (empty && !parity_err && !clash_err && !overflow && !underflow);
        end
    end

    a_r6_db_odd_parity: assert property (@(posedge clk) disable iff (rst)
        db_oe |-> (^{dbp_o, db_o}) == 1'b1);

    a_r9_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> parity_err);

    a_r8_clash_sticky: assert property (@(posedge clk) disable iff (rst)
        clash_err |=> clash_err);

    a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !pop_req) |=> (overflow && level == $past(level)));

    a_r11_empty_pop_dropped: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty && !push_req) |=> (underflow && empty));

    a_r10_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    a_r12_level_step: assert property (@(posedge clk) disable iff (rst)
        (level == $past(level)) || (level == $past(level) + 1'b1) ||
        (level + 1'b1 == $past(level)));
endmodule

bind hostdma_if hdi_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .full(fifo_full), .empty(fifo_empty), .level(u_fifo.level),
    .parity_err(parity_err), .clash_err(clash_err),
    .overflow(overflow), .underflow(underflow),
    .db_oe(db_oe), .db_o(db_o), .dbp_o(dbp_o)
);

// File: tb/sim_hostdma_if.sv
module sim_hostdma_if;
    logic       clk = 1'b0;
    logic       rst;
    logic       mux_mode;
    logic [7:0] pad_i, pad_o, db_i, db_o;
    logic [3:0] adr_i;
    logic       pad_oe, cs_n, rd_n, wr_n, dack_n, dwr_n, dma_rd_n;
    logic       dbp_i, dbp_o, db_oe;
    logic       parity_err, clash_err, overflow, underflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hostdma_if u0 (
        .clk(clk), .rst(rst), .mux_mode(mux_mode),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .adr_i(adr_i),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack_n(dack_n),
        .dwr_n(dwr_n), .dma_rd_n(dma_rd_n), .db_i(db_i), .dbp_i(dbp_i),
        .db_o(db_o), .dbp_o(dbp_o), .db_oe(db_oe),
        .parity_err(parity_err), .clash_err(clash_err),
        .overflow(overflow), .underflow(underflow)
    );

    // {op, addr, byte}; op 0 cpu write, 1 cpu read, 2 dma write, 3 dma read
    localparam logic [13:0] VEC [12] = '{
        {2'd0, 4'h1, 8'h5A},
        {2'd0, 4'h3, 8'hC3},
        {2'd0, 4'h0, 8'h11},
        {2'd1, 4'h1, 8'h5A},
        {2'd1, 4'h3, 8'hC3},
        {2'd2, 4'h0, 8'h01},
        {2'd2, 4'h0, 8'h80},
        {2'd0, 4'hF, 8'h77},
        {2'd1, 4'h0, 8'h11},
        {2'd3, 4'h0, 8'h01},
        {2'd3, 4'h0, 8'h80},
        {2'd1, 4'hF, 8'h77}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        pad_i = 8'h00; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        dack_n = 1'b1; dwr_n = 1'b1; dma_rd_n = 1'b1;
        db_i = 8'h00; dbp_i = 1'b1;
        adr_i = mux_mode ? 4'b0111 : 4'h0;
    endtask

    task automatic do_reset(input logic mm);
        rst = 1'b1;
        mux_mode = mm;
        idle();
        tick(6);
        rst = 1'b0;
        tick(5);
    endtask

    task automatic cpu_sel(input logic [3:0] a);
        if (!mux_mode) begin
            adr_i = a;
        end else begin
            pad_i = {4'h0, a};
            adr_i = 4'b1111;       // latch enable high, DMA read idle, low pins junk
            tick(4);
            adr_i[3] = 1'b0;
            tick(5);
        end
    endtask

    task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d, input int hold);
        cpu_sel(a);
        pad_i = d;
        cs_n = 1'b0;
        tick(2);
        wr_n = 1'b0;
        tick(hold);
        wr_n = 1'b1;
        tick(4);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d, output logic oe);
        cpu_sel(a);
        cs_n = 1'b0;
        rd_n = 1'b0;
        tick(5);
        d  = pad_o;
        oe = pad_oe;
        rd_n = 1'b1;
        tick(4);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic dma_wr(input logic [7:0] d, input bit good, input int hold);
        db_i  = d;
        dbp_i = good ? ~^d : ^d;
        dack_n = 1'b0;
        tick(2);
        dwr_n = 1'b0;
        tick(hold);
        dwr_n = 1'b1;
        tick(4);
        dack_n = 1'b1;
        tick(3);
    endtask

    task automatic set_drd(input logic v);
        if (mux_mode) adr_i[2] = v;
        else          dma_rd_n = v;
    endtask

    task automatic dma_rd(output logic [7:0] d, output logic p, output logic oe);
        dack_n = 1'b0;
        tick(2);
        set_drd(1'b0);
        tick(5);
        d = db_o; p = dbp_o; oe = db_oe;
        set_drd(1'b1);
        tick(4);
        dack_n = 1'b1;
        tick(3);
    endtask

    task automatic check_reset(input string tag);
        check(!pad_oe && !db_oe, tag, {7'b0, pad_oe, db_oe}, 9'h0);
        check({parity_err, clash_err, overflow, underflow} == 4'b0, tag,
              {5'b0, parity_err, clash_err, overflow, underflow}, 9'h0);
    endtask

    task automatic walk(input string mtag);
        logic [7:0] d;
        logic       p, oe;
        for (int i = 0; i < 12; i++) begin
            logic [1:0] op  = VEC[i][13:12];
            logic [3:0] a   = VEC[i][11:8];
            logic [7:0] val = VEC[i][7:0];
            case (op)
                2'd0: cpu_wr(a, val, 4);
                2'd1: begin
                    cpu_rd(a, d, oe);
                    check(d == val, (a == 4'hF) ? "R7" : mtag, {1'b0, d}, {1'b0, val});
                    check(oe == 1'b1, "R4", {8'b0, oe}, 9'h1);
                end
                2'd2: dma_wr(val, 1'b1, 4);
                default: begin
                    dma_rd(d, p, oe);
                    check(d == val, "R5", {1'b0, d}, {1'b0, val});
                    check(^{p, d} == 1'b1 && oe, "R6", {p, d}, {~^val, val});
                end
            endcase
        end
        check(!parity_err && !clash_err && !overflow && !underflow, mtag,
              {5'b0, parity_err, clash_err, overflow, underflow}, 9'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       p, oe;

        // R1 reset state, data-only mode
        do_reset(1'b0);
        check_reset("R1");

        // R2 R5 R6 R7 table walk in data-only mode
        walk("R2");

        // R4 enables need both pins
        cs_n = 1'b0; tick(3);
        check(!pad_oe, "R4", {8'b0, pad_oe}, 9'h0);
        cs_n = 1'b1; dack_n = 1'b0; tick(3);
        check(!db_oe, "R4", {8'b0, db_oe}, 9'h0);
        dack_n = 1'b1; tick(3);

        // R8 processor FIFO access during acknowledge is rejected
        do_reset(1'b0);
        dack_n = 1'b0;
        tick(3);
        cpu_wr(4'hF, 8'h99, 4);
        cpu_wr(4'h5, 8'h3C, 4);
        dack_n = 1'b1;
        tick(3);
        check(clash_err, "R8", {8'b0, clash_err}, 9'h1);
        cpu_rd(4'h5, d, oe);
        check(d == 8'h3C, "R8", {1'b0, d}, 9'h03C);
        // R11 FIFO still empty: a DMA read underflows
        check(!underflow, "R11", {8'b0, underflow}, 9'h0);
        dma_rd(d, p, oe);
        tick(2);
        check(underflow, "R11", {8'b0, underflow}, 9'h1);
        check(!overflow, "R11", {8'b0, overflow}, 9'h0);

        // R9 bad parity flagged, byte kept
        do_reset(1'b0);
        dma_wr(8'h3C, 1'b0, 4);
        check(parity_err, "R9", {8'b0, parity_err}, 9'h1);
        dma_rd(d, p, oe);
        check(d == 8'h3C, "R9", {1'b0, d}, 9'h03C);

        // R10 fill, overflow, drain in order
        for (int i = 0; i < 8; i++) dma_wr(8'(i * 17 + 3), 1'b1, 3);
        check(!overflow, "R10", {8'b0, overflow}, 9'h0);
        dma_wr(8'hEE, 1'b1, 3);
        check(overflow, "R10", {8'b0, overflow}, 9'h1);
        for (int i = 0; i < 8; i++) begin
            dma_rd(d, p, oe);
            check(d == 8'(i * 17 + 3), "R5", {1'b0, d}, {1'b0, 8'(i * 17 + 3)});
        end
        check(!underflow, "R10", {8'b0, underflow}, 9'h0);
        dma_rd(d, p, oe);
        tick(2);
        check(underflow, "R10", {8'b0, underflow}, 9'h1);

        // R12 long strobe moves one byte
        do_reset(1'b0);
        dma_wr(8'h42, 1'b1, 30);
        cpu_wr(4'hF, 8'h24, 25);
        dma_rd(d, p, oe);
        check(d == 8'h42, "R12", {1'b0, d}, 9'h042);
        cpu_rd(4'hF, d, oe);
        check(d == 8'h24, "R12", {1'b0, d}, 9'h024);
        check(!underflow, "R12", {8'b0, underflow}, 9'h0);
        dma_rd(d, p, oe);
        tick(2);
        check(underflow, "R12", {8'b0, underflow}, 9'h1);

        // R3 shared address/data mode
        do_reset(1'b1);
        check_reset("R1");
        walk("R3");
        // dedicated DMA read pin has no effect in shared mode
        dack_n = 1'b0; dma_rd_n = 1'b0; tick(4);
        check(!db_oe, "R3", {8'b0, db_oe}, 9'h0);
        dma_rd_n = 1'b1; dack_n = 1'b1; tick(4);
        check(!underflow, "R3", {8'b0, underflow}, 9'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule